// File: doc/BRIEF.md
# Power-Fail Access Supervisor

This block decides, from two digital comparator flags, whether a byte-wide memory and timekeeping core may be accessed. One flag says the supply is above the write-protect threshold. The other says it is above the battery-switch threshold. The block gates the host's chip-select and write strobe. It drives an active-low reset while the supply is out of tolerance and through a recovery interval after it returns. It selects the backup source when the supply falls below both thresholds, and it reports a battery-health flag.

The backup source cannot be connected until the supply has once risen above the write-protect threshold. That first rise arms backup operation, and it stays armed until the supervisor's own logic reset. The recovery interval is counted in milliseconds from a prescaler on the system clock, so both the cycles per millisecond and the interval length are parameters. A host write that is in progress when the supply fails is cut off at once. It stays suppressed until the host ends that cycle, so a stale strobe cannot complete the write after recovery.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n`, `mem_sel`, `mem_we`, `backup_sel` and `bat_armed` are all 0.
- R2: Each raw comparator input takes effect only after SYNC_STAGES rising clock edges (2 by default). A change driven between edges first shows on the outputs after the second following edge.
- R3: `mem_sel` equals `host_cs` only while the synchronized write-protect flag is 1 and reset is released. Otherwise it is 0. It falls in the same cycle the synchronized flag falls.
- R4: `rst_out_n` goes to 0 on the clock edge after the synchronized write-protect flag falls. It stays 0 while that flag is 0.
- R5: After the synchronized write-protect flag rises, `rst_out_n` rises exactly CYC_PER_MS*RECOV_MS clock edges later if the flag stays high.
- R6: If the write-protect flag drops during recovery, the recovery count restarts from zero on the next rise.
- R7: `bat_armed` becomes 1 on the edge after the synchronized write-protect flag is first 1. It stays 1, whatever the supply does, until `rst_n` is asserted.
- R8: `backup_sel` is 1 exactly when `bat_armed` is 1 and both synchronized flags are 0. Before arming it is never 1.
- R9: `mem_we` is `host_cs & host_we` while access is allowed. A write that is active (cs and we both 1) while access is not allowed is held off until `host_we` or `host_cs` returns to 0, even after reset is released.
- R10: `bat_good` follows the synchronized `bat_ok_raw` with SYNC_STAGES edges of latency. Host cycles have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the supervisor logic |
| vpf_above_raw | input | 1 | Asynchronous flag: supply above write-protect threshold |
| vso_above_raw | input | 1 | Asynchronous flag: supply above battery-switch threshold |
| bat_ok_raw | input | 1 | Asynchronous flag: battery voltage healthy |
| host_cs | input | 1 | Host chip select, active high |
| host_we | input | 1 | Host write strobe, active high |
| rst_out_n | output | 1 | Active-low reset to the system |
| mem_sel | output | 1 | Gated select to memory and clock registers |
| mem_we | output | 1 | Gated write strobe to memory and clock registers |
| backup_sel | output | 1 | 1 selects the backup source for internal power |
| bat_armed | output | 1 | Backup operation armed since the first valid power-up |
| bat_good | output | 1 | Battery health flag, read-only |

## Verification
The bench builds the supervisor with CYC_PER_MS = 4 and RECOV_MS = 3. This makes the recovery window 12 cycles, so the exact release edge, the edge before it and a restart in mid-count can all be hit directly. SYNC_STAGES stays at 2. The latency of each flag can then be checked edge by edge, including the one cycle where access is already blocked but reset has not yet fallen.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    PF_DOWN  = 2'd0,
    PF_RECOV = 2'd1,
    PF_UP    = 2'd2
  } pf_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_recovery.sv
module pfs_recovery
  import pfs_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int RECOV_MS   = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic released
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MS_W  = $clog2(RECOV_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(RECOV_MS - 1);

  pf_state_e        state_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             tick_ms;
  logic             terminal;

  assign tick_ms  = (pre_q == PRE_LAST);
  assign terminal = tick_ms && (ms_q == MS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_DOWN;
      pre_q   <= '0;
      ms_q    <= '0;
    end else if (!supply_ok) begin
      state_q <= PF_DOWN;
      pre_q   <= '0;
      ms_q    <= '0;
    end else if (state_q != PF_UP) begin
      if (terminal) begin
        state_q <= PF_UP;
        pre_q   <= '0;
        ms_q    <= '0;
      end else begin
        state_q <= PF_RECOV;
        if (tick_ms) begin
          pre_q <= '0;
          ms_q  <= ms_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign released = (state_q == PF_UP);

  // R6
  recov_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pre_q == '0) && (ms_q == '0) && (state_q == PF_DOWN));

  // R5
  recov_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(supply_ok));
endmodule

// File: rtl/pfs_gate.sv
module pfs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic access_ok,
  input  logic host_cs,
  input  logic host_we,
  output logic mem_sel,
  output logic mem_we
);
  logic host_wr;
  logic abort_q;

  assign host_wr = host_cs && host_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= host_wr && (abort_q || !access_ok);
  end

  assign mem_sel = host_cs && access_ok;
  assign mem_we  = host_wr && access_ok && !abort_q;

  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !access_ok) |=> (!mem_we || !$past(host_wr) || !host_wr) || !host_wr);

  // R9
  abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> !mem_we);
endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor #(
  parameter int CYC_PER_MS  = 50000,
  parameter int RECOV_MS    = 35,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vpf_above_raw,
  input  logic vso_above_raw,
  input  logic bat_ok_raw,
  input  logic host_cs,
  input  logic host_we,
  output logic rst_out_n,
  output logic mem_sel,
  output logic mem_we,
  output logic backup_sel,
  output logic bat_armed,
  output logic bat_good
);
  localparam int NFLAGS = 3;

  logic [NFLAGS-1:0] flags_s;
  logic              vpf_s;
  logic              vso_s;
  logic              released;
  logic              access_ok;
  logic              armed_q;

  pfs_sync #(.WIDTH(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({bat_ok_raw, vso_above_raw, vpf_above_raw}),
    .q_sync  (flags_s)
  );

  assign vpf_s    = flags_s[0];
  assign vso_s    = flags_s[1];
  assign bat_good = flags_s[2];

  pfs_recovery #(.CYC_PER_MS(CYC_PER_MS), .RECOV_MS(RECOV_MS)) u_recov (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (vpf_s),
    .released  (released)
  );

  assign access_ok = released && vpf_s;
  assign rst_out_n = released;

  pfs_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .access_ok (access_ok),
    .host_cs   (host_cs),
    .host_we   (host_we),
    .mem_sel   (mem_sel),
    .mem_we    (mem_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_q || vpf_s;
  end

  assign bat_armed  = armed_q;
  assign backup_sel = armed_q && !vpf_s && !vso_s;

  // R7
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_armed |=> bat_armed);

  // R8
  backup_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backup_sel |-> bat_armed);

  // R4
  reset_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpf_s) |=> !rst_out_n);

  // R3
  access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel || mem_we) |-> rst_out_n);
endmodule

// File: tb/tb_pwr_fail_supervisor.sv
module tb_pwr_fail_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n, vpf, vso, bat, cs, we;
  logic rst_out_n, mem_sel, mem_we, backup_sel, bat_armed, bat_good;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fail_supervisor #(.CYC_PER_MS(4), .RECOV_MS(3), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .vpf_above_raw(vpf), .vso_above_raw(vso),
    .bat_ok_raw(bat), .host_cs(cs), .host_we(we), .rst_out_n(rst_out_n),
    .mem_sel(mem_sel), .mem_we(mem_we), .backup_sel(backup_sel),
    .bat_armed(bat_armed), .bat_good(bat_good)
  );

  // fields: [16]vpf [15]vso [14]bat [13]cs [12]we [11:6]wait
  //         [5]rst [4]sel [3]we [2]backup [1]armed [0]batgood
  localparam logic [16:0] VEC [NV] = '{
    {5'b01110, 6'd4,  6'b000001},
    {5'b00110, 6'd4,  6'b000001},
    {5'b11110, 6'd14, 6'b110011},
    {5'b11111, 6'd1,  6'b111011},
    {5'b01111, 6'd3,  6'b000011},
    {5'b00111, 6'd3,  6'b000111},
    {5'b11111, 6'd16, 6'b110011},
    {5'b11110, 6'd1,  6'b110011},
    {5'b11111, 6'd1,  6'b111011},
    {5'b11011, 6'd3,  6'b111010}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vpf = 0; vso = 0; bat = 1; cs = 0; we = 0;
    waitn(3);
    // R1 reset state
    chk("R1", "rst_out_n", rst_out_n, 1'b0);
    chk("R1", "mem_sel", mem_sel, 1'b0);
    chk("R1", "mem_we", mem_we, 1'b0);
    chk("R1", "backup_sel", backup_sel, 1'b0);
    chk("R1", "bat_armed", bat_armed, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {vpf, vso, bat, cs, we} = VEC[i][16:12];
      waitn(int'(VEC[i][11:6]));
      chk("R4", $sformatf("vec%0d rst_out_n", i), rst_out_n, VEC[i][5]);
      chk("R3", $sformatf("vec%0d mem_sel", i), mem_sel, VEC[i][4]);
      chk("R9", $sformatf("vec%0d mem_we", i), mem_we, VEC[i][3]);
      chk("R8", $sformatf("vec%0d backup_sel", i), backup_sel, VEC[i][2]);
      chk("R7", $sformatf("vec%0d bat_armed", i), bat_armed, VEC[i][1]);
      chk("R10", $sformatf("vec%0d bat_good", i), bat_good, VEC[i][0]);
    end

    // R10: host writes do not touch bat_good
    bat = 1; waitn(3);
    chk("R10", "bat_good restored", bat_good, 1'b1);
    we = 0; waitn(1); we = 1; waitn(1);
    chk("R10", "bat_good after host write", bat_good, 1'b1);

    // R2 / R3 / R4: latency of a supply drop
    we = 0; cs = 1; vpf = 0;
    waitn(1);
    chk("R2", "mem_sel one edge after drop", mem_sel, 1'b1);
    waitn(1);
    chk("R3", "mem_sel two edges after drop", mem_sel, 1'b0);
    chk("R4", "rst_out_n two edges after drop", rst_out_n, 1'b1);
    waitn(1);
    chk("R4", "rst_out_n three edges after drop", rst_out_n, 1'b0);

    // R6: drop mid-recovery restarts count; R5 exact release edge
    vpf = 1; waitn(8);
    vpf = 0; waitn(3);
    vpf = 1; waitn(13);
    chk("R6", "rst_out_n one edge before release", rst_out_n, 1'b0);
    waitn(1);
    chk("R5", "rst_out_n at release edge", rst_out_n, 1'b1);

    // R7 / R8: armed backup, then reset clears arming
    vpf = 0; vso = 0; waitn(3);
    chk("R8", "backup_sel armed and below both", backup_sel, 1'b1);
    rst_n = 1'b0; waitn(2); rst_n = 1'b1; waitn(3);
    chk("R7", "bat_armed after logic reset", bat_armed, 1'b0);
    chk("R8", "backup_sel unarmed", backup_sel, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule